// File: doc/BRIEF.md
# Three-Decade Programmable BCD Divider

This block divides a fast clock, normally one taken from a VCO, by a modulus N and gives one narrow pulse every N input cycles. It sits in the feedback path of a phase-locked loop. With a 1 kHz reference at the phase comparator, the loop locks the VCO at N times 1 kHz, so the settings span 3 kHz to 999 kHz in 1 kHz steps. The comparator that follows must act on edges, because the divided output is far from a square wave.

N is given as three decimal digits, as thumbwheel switches would give it. It is counted down in three cascaded BCD decades, not as a binary word. The digits are sampled only when the counter reloads: at reset and at each terminal count. A setting that changes in the middle of a period therefore never yields a short or stretched period. A digit above nine counts as nine, and any modulus below three counts as three.

Top module: `bcd_modulus_divider`

## Requirements
- R1: With digits H, T, U on `modulus_bcd` (hundreds in bits 11:8, tens in bits 7:4, units in bits 3:0), `pulse_o` is high for exactly one clock cycle in every N = 100*H + 10*T + U cycles.
- R2: After `rst` goes low, the first `pulse_o` appears in the cycle after the N-th rising edge sampled with `rst` low. The following pulses come every N edges after that.
- R3: `tc_o` is high only in the cycle just before each `pulse_o` cycle. It is never high at the same time as `pulse_o`.
- R4: A digit value from 10 to 15, in any position, acts as the digit 9. For example, units 12 with tens and hundreds zero divides by 9, and hundreds 15 with the other digits zero divides by 900.
- R5: A modulus of 0, 1 or 2, after saturating the digits, acts as a modulus of 3.
- R6: The digits are captured at the rising edge where `tc_o` is high, and at reset. A change at any other time does not alter the period already under way. It sets the length of the period that starts at the next reload.
- R7: While `rst` is high at a rising edge, `pulse_o` and `tc_o` are low afterwards and the count restarts from the present digits.
- R8: The full range works up to the largest modulus: 999, made from either 9,9,9 or from out-of-range digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high; loads the modulus |
| modulus_bcd | input | 12 | Three BCD digits of N: hundreds 11:8, tens 7:4, units 3:0 |
| pulse_o | output | 1 | Divided output: one-cycle pulse per N clocks |
| tc_o | output | 1 | Terminal count: the counter holds 1 and reloads at the next edge |

## Verification
The hardest case to reach is a digit change that lands in the cycle before a reload. A change there must set the next period, while a change one cycle earlier in the same window must leave the current period alone. The bench measures many periods from reset and times its digit writes by counting clocks from reset release. It changes the digits at a chosen count: mid-period and in the terminal-count cycle itself. It measures both the period in progress and the period that follows. Out-of-range digits get their own sweep, one position at a time, because a borrow wrapping into a saturated decade only shows when that decade holds the 9.

// File: rtl/bcdiv_pkg.sv
package bcdiv_pkg;

   localparam int unsigned BCD_W = 4;

   typedef logic [BCD_W-1:0] bcd_t;

   localparam bcd_t BCD_MAX = bcd_t'(9);
   localparam bcd_t BCD_ONE = bcd_t'(1);

   // saturate a nibble into the legal decimal range
   function automatic bcd_t bcd_sat(input bcd_t d);
      return (d > BCD_MAX) ? BCD_MAX : d;
   endfunction

endpackage

// File: rtl/bcdiv_sanitize.sv
module bcdiv_sanitize
   import bcdiv_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3,
   parameter int unsigned MIN_MOD     = 3
) (
   input  logic [NUM_DECADES*BCD_W-1:0] raw_i,
   output logic [NUM_DECADES*BCD_W-1:0] clean_o
);

   localparam int unsigned VEC_W   = NUM_DECADES * BCD_W;
   localparam bcd_t        MIN_DIG = bcd_t'(MIN_MOD);

   logic [VEC_W-1:0] sat;
   logic             upper_zero;

   for (genvar g = 0; g < NUM_DECADES; g++) begin : g_sat
      assign sat[g*BCD_W +: BCD_W] = bcd_sat(raw_i[g*BCD_W +: BCD_W]);
   end

   if (NUM_DECADES == 1) begin : g_single
      assign upper_zero = 1'b1;
   end else begin : g_multi
      assign upper_zero = (sat[VEC_W-1:BCD_W] == '0);
   end

   always_comb begin
      clean_o = sat;
      if (upper_zero && (sat[BCD_W-1:0] < MIN_DIG))
         clean_o[BCD_W-1:0] = MIN_DIG;
   end

endmodule

// File: rtl/bcdiv_decade.sv
module bcdiv_decade
   import bcdiv_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   input  bcd_t load_val_i,
   input  logic dec_i,
   output bcd_t q_o
);

   always_ff @(posedge clk) begin
      if (load_i)
         q_o <= load_val_i;
      else if (dec_i)
         q_o <= (q_o == '0) ? BCD_MAX : (q_o - BCD_ONE);
   end

   // R4: a saturated load keeps every decade inside 0..9
   p_digit_legal_r4: assert property (@(posedge clk) disable iff (rst)
      q_o <= BCD_MAX);

   // R1: a borrow out of zero wraps to nine
   p_wrap_nine_r1: assert property (@(posedge clk) disable iff (rst)
      (!load_i && dec_i && q_o == '0) |=> (q_o == BCD_MAX));

endmodule

// File: rtl/bcdiv_terminal.sv
module bcdiv_terminal
   import bcdiv_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3
) (
   input  logic [NUM_DECADES*BCD_W-1:0] count_i,
   output logic                         at_one_o
);

   localparam int unsigned VEC_W = NUM_DECADES * BCD_W;

   logic upper_clear;

   if (NUM_DECADES == 1) begin : g_single
      assign upper_clear = 1'b1;
   end else begin : g_multi
      assign upper_clear = (count_i[VEC_W-1:BCD_W] == '0);
   end

   assign at_one_o = upper_clear && (count_i[BCD_W-1:0] == BCD_ONE);

endmodule

// File: rtl/bcd_modulus_divider.sv
module bcd_modulus_divider
   import bcdiv_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3,
   parameter int unsigned MIN_MOD     = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_DECADES*BCD_W-1:0] modulus_bcd,
   output logic                         pulse_o,
   output logic                         tc_o
);

   localparam int unsigned VEC_W = NUM_DECADES * BCD_W;

   if (NUM_DECADES < 1 || NUM_DECADES > 6) begin : g_bad_decades
      $error("bcd_modulus_divider: NUM_DECADES must be 1..6");
   end
   if (MIN_MOD < 2 || MIN_MOD > 9) begin : g_bad_min
      $error("bcd_modulus_divider: MIN_MOD must be 2..9");
   end

   logic [VEC_W-1:0]       clean_mod;
   logic [VEC_W-1:0]       count;
   logic [NUM_DECADES-1:0] dec_chain;
   logic                   at_one;
   logic                   reload;

   bcdiv_sanitize #(
      .NUM_DECADES (NUM_DECADES),
      .MIN_MOD     (MIN_MOD)
   ) u_sanitize (
      .raw_i   (modulus_bcd),
      .clean_o (clean_mod)
   );

   assign reload       = rst | at_one;
   assign dec_chain[0] = 1'b1;

   for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
      bcdiv_decade u_decade (
         .clk        (clk),
         .rst        (rst),
         .load_i     (reload),
         .load_val_i (clean_mod[g*BCD_W +: BCD_W]),
         .dec_i      (dec_chain[g]),
         .q_o        (count[g*BCD_W +: BCD_W])
      );
      if (g < NUM_DECADES - 1) begin : g_borrow
         assign dec_chain[g+1] = dec_chain[g] & (count[g*BCD_W +: BCD_W] == '0);
      end
   end

   bcdiv_terminal #(
      .NUM_DECADES (NUM_DECADES)
   ) u_terminal (
      .count_i  (count),
      .at_one_o (at_one)
   );

   assign tc_o = at_one & ~rst;

   always_ff @(posedge clk) begin
      if (rst)
         pulse_o <= 1'b0;
      else
         pulse_o <= at_one;
   end

   // R1: the divided pulse lasts one cycle
   p_pulse_narrow_r1: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

   // R3: every terminal count is followed by a pulse
   p_tc_to_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      tc_o |=> pulse_o);

   // R3: a pulse only follows a terminal count
   p_pulse_from_tc_r3: assert property (@(posedge clk) disable iff (rst)
      pulse_o |-> $past(tc_o));

   // R5: a reload never lands at or below the terminal value
   p_reload_min_r5: assert property (@(posedge clk) disable iff (rst)
      pulse_o |-> !tc_o);

endmodule

// File: tb/sim_bcd_modulus_divider.sv
`timescale 1ns/1ps
module sim_bcd_modulus_divider;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] modulus_bcd = 12'h000;
   logic        pulse_o;
   logic        tc_o;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 0;

   always #10 clk = ~clk;

   bcd_modulus_divider u0 (
      .clk         (clk),
      .rst         (rst),
      .modulus_bcd (modulus_bcd),
      .pulse_o     (pulse_o),
      .tc_o        (tc_o)
   );

   function automatic int sat9(input logic [3:0] d);
      return (d > 4'd9) ? 9 : int'(d);
   endfunction

   function automatic int eff_mod(input logic [11:0] v);
      int n;
      n = 100*sat9(v[11:8]) + 10*sat9(v[7:4]) + sat9(v[3:0]);
      return (n < 3) ? 3 : n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // measures one period; optionally rewrites the digits at clock count change_at
   task automatic measure(input int exp_n, input string req,
                          input int change_at, input logic [11:0] new_dig);
      int cnt;
      int tc_err;
      cnt = 0;
      tc_err = 0;
      forever begin
         @(negedge clk);
         cnt++;
         if (tc_o !== (cnt == exp_n - 1)) tc_err++;
         if (pulse_o === 1'b1 || cnt > 1100) break;
         if (change_at != 0 && cnt == change_at) modulus_bcd = new_dig;
      end
      chk(cnt == exp_n, req, cnt, exp_n);
      chk(tc_err == 0, "R3 tc_o only before pulse", tc_err, 0);
   endtask

   task automatic reset_with(input logic [11:0] dig);
      @(negedge clk);
      rst = 1'b1;
      modulus_bcd = dig;
      @(negedge clk);
      @(negedge clk);
      chk(pulse_o === 1'b0 && tc_o === 1'b0, "R7 outputs low in reset",
          int'({pulse_o, tc_o}), 0);
      rst = 1'b0;
   endtask

   task automatic run_case(input logic [11:0] dig, input string req);
      int n;
      n = eff_mod(dig);
      reset_with(dig);
      measure(n, {req, " R2 first period"}, 0, 12'h000);
      measure(n, {req, " R1 steady period"}, 0, 12'h000);
   endtask

   initial begin
      // R1 R2 R5: every modulus 0..199 from legal digits
      for (int v = 0; v < 200; v++) begin
         logic [11:0] d;
         d = {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
         run_case(d, (v < 3) ? "R5 small modulus" : "R1 sweep");
      end

      // R4: out-of-range digit in each position
      for (int x = 10; x < 16; x++) begin
         run_case({4'd0, 4'd0, 4'(x)}, "R4 units saturate");
         run_case({4'd0, 4'(x), 4'd0}, "R4 tens saturate");
         run_case({4'(x), 4'd0, 4'd0}, "R4 hundreds saturate");
      end

      // R8: largest modulus
      run_case(12'h999, "R8 max legal");
      run_case(12'hFFF, "R8 max saturated");
      run_case(12'h990, "R8 borrow across decades");

      // R6: mid-period change keeps the running period, next uses new value
      reset_with(12'h050);
      measure(50, "R6 mid change ignored", 20, 12'h007);
      measure(7, "R6 new value after reload", 0, 12'h000);

      // R6: change in the terminal-count cycle applies to the next period
      reset_with(12'h012);
      measure(12, "R6 change at tc keeps period", 11, 12'h005);
      measure(5, "R6 change at tc takes effect", 0, 12'h000);

      // R6: change one cycle before tc still ignored for current period
      reset_with(12'h010);
      measure(10, "R6 change before tc", 8, 12'h004);
      measure(4, "R6 next period uses latest", 0, 12'h000);

      // R7: reset in mid-period restarts the count
      reset_with(12'h030);
      repeat (15) @(negedge clk);
      run_case(12'h011, "R7 restart after reset");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #4ms;
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule